// File: doc/BRIEF.md
# W-tiled to linear coordinate translator

The block maps a byte coordinate pair (x, y) in a surface stored in 64-by-64-byte W-tiles to the coordinate pair (x_p, y_p) that addresses the same byte in a linear surface. The linear surface has a row pitch in bytes that is set per request. The tiled byte offset is split into two parts. The coarse part is C = (x & 0xFFF8)*64 + 8*(y & 0x3C). It is divided by the pitch, and the quotient goes to the linear row. The fine part is five bits of x and y interleaved. These bits are added straight to the remainder to form the linear column.

Each request is accepted with a valid/ready handshake while the block is idle. A restoring divider then produces one quotient bit per clock over the 22 bits of C. The result is registered and held on the output until the consumer takes it. A pitch of zero is treated as illegal. The block finishes such a request at once, with an error flag and zero coordinates.

Top module: `wtile_to_linear`

## Requirements
- R1: `in_ready` is high only while the block is idle. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high, and `in_ready` is low in the cycle after an acceptance.
- R2: For a nonzero pitch s, `y_p` = ((y & 0xFFC0) + floor(C / s)) mod 65536, where C = (x & 0xFFF8)*64 + 8*(y & 0x3C).
- R3: For a nonzero pitch s, `x_p` = ((C mod s) + 16*x[2] + 8*y[1] + 4*x[1] + 2*y[0] + x[0]) mod 65536.
- R4: When neither result wraps, `y_p`*s + `x_p` equals the tiled byte offset. That offset is (y/64)*64*s + (x/64)*4096 + 512*((x%64)/8) + 64*((y%64)/8) + 32*y[2] + 16*x[2] + 8*y[1] + 4*x[1] + 2*y[0] + x[0].
- R5: For a nonzero pitch, `out_valid` rises exactly 22 clock edges after the accepting edge.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `x_p`, `y_p` and `err` hold their values. The block returns to idle on the edge where `out_valid` and `out_ready` are both high.
- R7: A pitch of zero gives `out_valid` on the first edge after acceptance, with `err` = 1 and `x_p` = `y_p` = 0.
- R8: After reset, `in_ready` = 1 and `out_valid` = 0.
- R9: A result for a nonzero pitch has `err` = 0.
- R10: `in_valid` and the request inputs have no effect while the block is busy or holding a result. The result delivered is the one for the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request can be taken |
| x_in | input | 16 | Tiled byte column x |
| y_in | input | 16 | Tiled row y |
| stride | input | 16 | Linear row pitch in bytes |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| x_p | output | 16 | Linear byte column |
| y_p | output | 16 | Linear row |
| err | output | 1 | Pitch was zero |

## Verification
A result for a nonzero pitch is due on the 22nd edge after the accepting edge. A zero-pitch result is due on the first edge after acceptance. The ready output falls on the edge after acceptance and returns on the edge after the output handshake. The bench keeps a behavioural model that advances at each rising edge with the same countdown. It compares every output at each falling edge, so a result that arrives one cycle early or late, or changes while stalled, is caught in that cycle. At each delivery it also checks the byte-offset identity from the full tile formula.

// File: rtl/wtile_to_linear.sv
module wtile_to_linear #(
  parameter int CW = 16,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] x_in,
  input  logic [CW-1:0] y_in,
  input  logic [SW-1:0] stride,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] x_p,
  output logic [CW-1:0] y_p,
  output logic          err
);
  localparam int OW   = CW + 6;
  localparam int CNTW = $clog2(OW);

  typedef enum logic [1:0] {IDLE, BUSY, DONE} st_t;
  st_t st;

  logic [CNTW-1:0] cnt;
  logic [OW-1:0]   dvd;
  logic [SW-1:0]   rem, div;
  logic [2:0]      x_lo;
  logic [CW-1:0]   y_r;
  logic [CW-1:0]   xo, yo;
  logic            eo;

  logic [SW:0]   rem_sh, sub;
  logic          ge;
  logic [SW-1:0] rem_nx;
  logic [OW-1:0] q_fin;
  logic [4:0]    fine;
  logic          acc;

  assign acc    = in_valid && in_ready;
  assign rem_sh = {rem, dvd[OW-1]};
  assign sub    = rem_sh - {1'b0, div};
  assign ge     = ~sub[SW];
  assign rem_nx = ge ? sub[SW-1:0] : rem_sh[SW-1:0];
  assign q_fin  = {dvd[OW-2:0], ge};
  assign fine   = {x_lo[2], y_r[1], x_lo[1], y_r[0], x_lo[0]};

  assign in_ready  = (st == IDLE);
  assign out_valid = (st == DONE);
  assign x_p = xo;
  assign y_p = yo;
  assign err = eo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; dvd <= '0; rem <= '0; div <= '0;
      x_lo <= '0; y_r <= '0; xo <= '0; yo <= '0; eo <= 1'b0;
    end else begin
      case (st)
        IDLE: if (acc) begin
          x_lo <= x_in[2:0];
          y_r  <= y_in;
          div  <= stride;
          dvd  <= {x_in[CW-1:3], y_in[5:2], 5'b0};
          rem  <= '0;
          cnt  <= '0;
          if (stride == '0) begin
            xo <= '0; yo <= '0; eo <= 1'b1; st <= DONE;
          end else begin
            eo <= 1'b0; st <= BUSY;
          end
        end
        BUSY: begin
          dvd <= q_fin;
          rem <= rem_nx;
          cnt <= cnt + 1'b1;
          if (cnt == CNTW'(OW - 1)) begin
            xo <= CW'(rem_nx) + CW'(fine);
            yo <= {y_r[CW-1:6], 6'b0} + q_fin[CW-1:0];
            st <= DONE;
          end
        end
        DONE: if (out_ready) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  // R1: nothing accepted in the cycle after an acceptance
  p_one_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !in_ready);

  // R2: remainder stays below the pitch during the divide
  p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BUSY) |-> (rem < div));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(x_p) && $stable(y_p) && $stable(err)));

  p_zero_fast_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && stride == '0) |=> (out_valid && err));

  p_zero_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && err) |-> (x_p == '0 && y_p == '0));

  p_no_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && stride != '0) |=> (!err && !out_valid));
endmodule

// File: tb/tb_wtile_to_linear.sv
`timescale 1ns/1ps
module tb_wtile_to_linear;
  localparam int LAT = 22;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 1;
  logic [15:0] x_in = 0, y_in = 0, stride = 0;
  logic in_ready, out_valid, err;
  logic [15:0] x_p, y_p;

  wtile_to_linear dut (.clk, .rst_n, .in_valid, .in_ready, .x_in, .y_in, .stride,
                       .out_valid, .out_ready, .x_p, .y_p, .err);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0, id_checks = 0;
  bit random_ready = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural model
  int m_state = 0, m_cnt = 0;
  longint e_x, e_y, m_xi, m_yi, m_s;
  bit e_err;

  function automatic void calc(longint x, longint y, longint s);
    longint c, q, r;
    m_xi = x; m_yi = y; m_s = s;
    if (s == 0) begin e_x = 0; e_y = 0; e_err = 1; return; end
    c = (x & 16'hFFF8) * 64 + 8 * (y & 16'h3C);
    q = c / s; r = c % s;
    e_y = ((y & 16'hFFC0) + q) % 65536;
    e_x = (r + 4*(x & 4) + 4*(y & 2) + 2*(x & 2) + 2*(y & 1) + (x & 1)) % 65536;
    e_err = 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) m_state = 0;
    else case (m_state)
      0: if (in_valid) begin
           calc(x_in, y_in, stride);
           if (stride == 0) m_state = 2;
           else begin m_state = 1; m_cnt = LAT; end
         end
      1: begin m_cnt--; if (m_cnt == 0) m_state = 2; end
      default: if (out_ready) m_state = 0;
    endcase
  end

  bit prev_done = 0, id_done = 0;
  logic [15:0] px, py;

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(in_ready == (m_state == 0), "R1/R10 in_ready", in_ready, m_state == 0);
      chk(out_valid == (m_state == 2), "R5 out_valid", out_valid, m_state == 2);
      if (m_state == 2) begin
        chk(y_p == e_y, e_err ? "R7 y_p" : "R2 y_p", y_p, e_y);
        chk(x_p == e_x, e_err ? "R7 x_p" : "R3 x_p", x_p, e_x);
        chk(err == e_err, e_err ? "R7 err" : "R9 err", err, e_err);
        if (prev_done) begin
          chk(x_p == px && y_p == py, "R6 hold", {x_p, y_p}, {px, py});
        end
        if (!id_done && !e_err) begin
          longint off, raw_y, raw_x, x, y, s;
          x = m_xi; y = m_yi; s = m_s;
          raw_y = (y & 16'hFFC0) + ((x & 16'hFFF8) * 64 + 8 * (y & 16'h3C)) / s;
          raw_x = ((x & 16'hFFF8) * 64 + 8 * (y & 16'h3C)) % s + 31;
          if (raw_y < 65536 && raw_x < 65536) begin
            off = (y/64)*64*s + (x/64)*4096 + 512*((x%64)/8) + 64*((y%64)/8)
                + 32*((y>>2)&1) + 16*((x>>2)&1) + 8*((y>>1)&1) + 4*((x>>1)&1)
                + 2*(y&1) + (x&1);
            id_checks++;
            chk(longint'(y_p)*s + x_p == off, "R4 identity", longint'(y_p)*s + x_p, off);
          end
          id_done = 1;
        end
        px = x_p; py = y_p;
      end
      prev_done = (m_state == 2) && !out_ready;
      if (m_state != 2) id_done = 0;
    end
    out_ready = random_ready ? ($urandom % 4 == 0) : 1'b1;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic req(logic [15:0] x, logic [15:0] y, logic [15:0] s, int junk);
    @(negedge clk);
    in_valid = 1; x_in = x; y_in = y; stride = s;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    // R10: requests presented while busy must be ignored
    for (int i = 0; i < junk && m_state == 1 && m_cnt > 2; i++) begin
      in_valid = 1; x_in = 16'($urandom); y_in = 16'($urandom); stride = 16'($urandom);
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready == 1 && out_valid == 0, "R8 reset", {in_ready, out_valid}, 2'b10);
    req(0, 0, 64, 0);
    req(16'hFFFF, 16'hFFFF, 16'hFFFF, 0);
    req(100, 37, 128, 0);
    req(63, 63, 64, 0);
    req(5, 7, 1, 0);
    req(9, 9, 0, 0);
    req(16'hFFFF, 63, 0, 0);
    req(200, 300, 4096, 5);
    random_ready = 1;
    for (int n = 0; n < 300; n++) begin
      logic [15:0] s;
      s = (n % 25 == 0) ? 16'd0 : 16'($urandom_range(64, 16384));
      req(16'($urandom_range(0, 4095)), 16'($urandom_range(0, 4095)), s, (n % 3 == 0) ? 4 : 0);
    end
    for (int n = 0; n < 40; n++)
      req(16'($urandom), 16'($urandom), 16'($urandom_range(1, 65535)), 0);
    random_ready = 0;
    while (m_state != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(id_checks > 100, "R4 identity count", id_checks, 100);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule